// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame is kept. Each frame arrives as an identifier, a flag that marks it standard (11-bit) or extended (29-bit), and the number of the controller that received it. The block compares the frame against identifier tables held in one internal table RAM. It then reports whether the frame was accepted, which table entry matched, and a one-cycle done strobe. An accepted frame also raises a one-cycle receive-interrupt pulse. A rejected frame gives no interrupt and is simply not kept.

The RAM has `2**ADDR_W` words of 32 bits, which is 512 words by default. Standard entries are packed two to a word and extended entries take a whole word. So the RAM holds up to twice as many standard entries as extended ones, or any mix of the two. Five boundary registers split the RAM into four consecutive sections:
- standard single identifiers
- standard identifier ranges
- extended single identifiers
- extended identifier ranges

A standard frame is checked only against the two standard sections, and an extended frame only against the two extended sections. The search is a sequential scan of one word per clock and stops at the first hit. A host write port loads both the RAM and the boundary registers. The port is locked out while a search runs, so a search never sees a table that is only partly updated.

Top module: `can_id_filter`

## Requirements
- R1: After reset, `busy`, `done`, `accept` and `rx_irq` are 0. All five boundary registers are 0, so every section is empty.
- R2: A word in the standard-single section holds two 16-bit entries. Each entry is laid out as controller number in [15:13], bits [12:11] unused, and identifier in [10:0]. The entry in word bits [31:16] has index 2·addr and the entry in [15:0] has index 2·addr+1. A standard frame matches an entry when both the identifier and the controller number are equal.
- R3: A word in the standard-range section holds a lower bound in [31:16] and an upper bound in [15:0], both in the R2 layout. A standard frame matches when its identifier lies between the two bounds, inclusive, and its controller number equals the one in the lower-bound entry. The reported index is 2·addr.
- R4: A word in the extended-single section holds the controller number in [31:29] and a 29-bit identifier in [28:0]. An extended frame matches on equal identifier and controller number. The reported index is addr.
- R5: The extended-range section is read as pairs of words, counted from the section start. The even word holds the lower bound and the odd word holds the upper bound, both in the R4 layout. A frame matches when lower ≤ identifier ≤ upper and its controller number equals the one in the lower word. The reported index is the address of the lower word.
- R6: A standard frame scans only the addresses from the standard-single start up to, but not including, the extended-single start. An extended frame scans only from the extended-single start up to, but not including, the end pointer. When several entries match, the one with the lowest index is reported.
- R7: `done` is a one-cycle pulse. `accept` and `hit_index` hold their values until the next request is taken. `rx_irq` pulses together with `done` only when the frame is accepted; a miss leaves `rx_irq` low and `accept` 0.
- R8: If the address range that a frame would scan is empty, the search still ends with `done` and `accept` = 0.
- R9: A request made while `busy` is high is ignored. It neither changes the result in progress nor produces a second `done`.
- R10: Host writes made while `busy` is high are dropped, for both the table RAM and the boundary registers.
- R11: When `wr_addr[ADDR_W]` = 0, a write goes to RAM word `wr_addr[ADDR_W-1:0]`. When it is 1, a write sets boundary register `wr_addr[2:0]` from `wr_data[ADDR_W:0]`. The registers are: 0 = standard-single start, 1 = standard-range start, 2 = extended-single start, 3 = extended-range start, 4 = end pointer.
- R12: An entry whose identifier matches but whose controller number differs from the frame's controller number does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W+1 | Host write address; the top bit selects the boundary registers |
| wr_data | input | 32 | Host write data |
| lk_req | input | 1 | Lookup request strobe |
| lk_ext | input | 1 | 1 = extended frame, 0 = standard frame |
| lk_id | input | 29 | Frame identifier; a standard frame uses bits [10:0] |
| lk_ctrl | input | 3 | Number of the controller that received the frame |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle strobe marking the end of a search |
| accept | output | 1 | Frame accepted; held until the next request |
| hit_index | output | ADDR_W+1 | Index of the matching entry; held until the next request |
| rx_irq | output | 1 | Receive-interrupt pulse raised for an accepted frame |

## Verification
The bench builds the block with `ADDR_W` = 6, which gives a 64-word table. With this size, all four sections and their boundaries fit in a dozen words and every scan finishes in a few cycles. Such short scans make it practical to reach several cases: a request or a host write landing in the middle of a search, an extended range pair that straddles a word boundary, and sections made empty by moving a single boundary register. The default size changes only the address width and the scan length, not the compare logic or the control sequence.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  localparam int CTRL_W = 3;
  localparam int SID_W  = 11;
  localparam int EID_W  = 29;
  localparam int WORD_W = 32;
  localparam int NBND   = 5;

  typedef enum logic [1:0] {
    SEC_STD_ONE = 2'd0,
    SEC_STD_RNG = 2'd1,
    SEC_EXT_ONE = 2'd2,
    SEC_EXT_RNG = 2'd3
  } sec_kind_e;

  function automatic logic [CTRL_W-1:0] half_ctrl(input logic [15:0] h);
    return h[15:13];
  endfunction

  function automatic logic [SID_W-1:0] half_id(input logic [15:0] h);
    return h[SID_W-1:0];
  endfunction

endpackage

// File: rtl/filt_table_ram.sv
module filt_table_ram #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_busy,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  // R10: the table is never written while a scan reads it
  a_r10_no_write_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !scan_busy);

endmodule

// File: rtl/filt_bounds.sv
module filt_bounds #(
  parameter int AW = 9
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [2:0]                          wr_idx,
  input  logic [AW:0]                         wr_val,
  output logic [can_filt_pkg::NBND-1:0][AW:0] bnd
);
  import can_filt_pkg::*;

  for (genvar g = 0; g < NBND; g++) begin : g_reg
    logic        ld;
    logic [AW:0] val_q;
    assign ld = wr_en && (wr_idx == 3'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (ld) val_q <= wr_val;
    end
    assign bnd[g] = val_q;
  end

endmodule

// File: rtl/filt_match.sv
module filt_match
  import can_filt_pkg::*;
(
  input  sec_kind_e               kind,
  input  logic [WORD_W-1:0]       word,
  input  logic [WORD_W-1:0]       prev_word,
  input  logic                    pair_upper,
  input  logic [EID_W-1:0]        key_id,
  input  logic [CTRL_W-1:0]       key_ctrl,
  output logic                    hit,
  output logic                    hit_low_half
);
  logic [15:0]      hi_h, lo_h;
  logic [SID_W-1:0] sid;
  logic             m_hi, m_lo, in_srng, in_erng;
  logic [3:0]       unused_bits;

  assign hi_h = word[31:16];
  assign lo_h = word[15:0];
  assign sid  = key_id[SID_W-1:0];
  assign unused_bits = {hi_h[12:11], lo_h[12:11]};

  always_comb begin
    m_hi    = (half_ctrl(hi_h) == key_ctrl) && (half_id(hi_h) == sid);
    m_lo    = (half_ctrl(lo_h) == key_ctrl) && (half_id(lo_h) == sid);
    in_srng = (half_ctrl(hi_h) == key_ctrl) &&
              (half_id(hi_h) <= sid) && (sid <= half_id(lo_h));
    in_erng = pair_upper && (prev_word[31:29] == key_ctrl) &&
              (prev_word[EID_W-1:0] <= key_id) && (key_id <= word[EID_W-1:0]);
    hit          = 1'b0;
    hit_low_half = 1'b0;
    unique case (kind)
      SEC_STD_ONE: begin
        hit          = m_hi || m_lo;
        hit_low_half = !m_hi;
      end
      SEC_STD_RNG: hit = in_srng;
      SEC_EXT_ONE: hit = (word[31:29] == key_ctrl) && (word[EID_W-1:0] == key_id);
      SEC_EXT_RNG: hit = in_erng;
      default:     hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/filt_scan_ctrl.sv
module filt_scan_ctrl
  import can_filt_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  ext,
  input  logic [EID_W-1:0]      id,
  input  logic [CTRL_W-1:0]     ctrl,
  input  logic [NBND-1:0][AW:0] bnd,
  output logic                  ram_re,
  output logic [AW-1:0]         ram_raddr,
  input  logic [WORD_W-1:0]     ram_rdata,
  output sec_kind_e             cmp_kind,
  output logic                  cmp_pair_upper,
  output logic [WORD_W-1:0]     cmp_prev,
  output logic [EID_W-1:0]      key_id,
  output logic [CTRL_W-1:0]     key_ctrl,
  input  logic                  cmp_hit,
  input  logic                  cmp_low_half,
  output logic                  busy,
  output logic                  done,
  output logic                  accept,
  output logic [AW:0]           hit_index,
  output logic                  rx_irq
);
  logic              busy_q, busy_d, iss_q, iss_d, v1_q, v1_d;
  logic [AW:0]       ia_q, ia_d, a1_q, a1_d, lim_q, lim_d, start, off, ia_inc;
  logic [WORD_W-1:0] prev_q, prev_d;
  logic              done_q, done_d, acc_q, acc_d, irq_q, irq_d;
  logic [AW:0]       idx_q, idx_d, idx_hit;
  logic              key_ld;
  logic [EID_W-1:0]  kid_q;
  logic [CTRL_W-1:0] kct_q;

  assign key_ld = req && !busy_q;
  assign ia_inc = ia_q + 1'b1;
  assign off    = a1_q - bnd[3];
  assign start  = ext ? bnd[2] : bnd[0];

  // section of the word under compare
  always_comb begin
    if (a1_q < bnd[1])      cmp_kind = SEC_STD_ONE;
    else if (a1_q < bnd[2]) cmp_kind = SEC_STD_RNG;
    else if (a1_q < bnd[3]) cmp_kind = SEC_EXT_ONE;
    else                    cmp_kind = SEC_EXT_RNG;
  end
  assign cmp_pair_upper = off[0];

  always_comb begin
    unique case (cmp_kind)
      SEC_STD_ONE: idx_hit = {a1_q[AW-1:0], cmp_low_half};
      SEC_STD_RNG: idx_hit = {a1_q[AW-1:0], 1'b0};
      SEC_EXT_ONE: idx_hit = a1_q;
      default:     idx_hit = a1_q - 1'b1;
    endcase
  end

  // next state
  always_comb begin
    busy_d = busy_q; iss_d = iss_q; v1_d = v1_q;
    ia_d = ia_q; a1_d = a1_q; lim_d = lim_q; prev_d = prev_q;
    done_d = 1'b0; irq_d = 1'b0; acc_d = acc_q; idx_d = idx_q;
    if (!busy_q) begin
      if (req) begin
        busy_d = 1'b1;
        ia_d   = start;
        lim_d  = ext ? bnd[4] : bnd[2];
        iss_d  = start < lim_d;
        v1_d   = 1'b0;
        acc_d  = 1'b0;
        idx_d  = '0;
      end
    end else begin
      if (v1_q) prev_d = ram_rdata;
      if (v1_q && cmp_hit) begin
        done_d = 1'b1; irq_d = 1'b1; acc_d = 1'b1; idx_d = idx_hit;
        busy_d = 1'b0; iss_d = 1'b0; v1_d = 1'b0;
      end else if (!iss_q && !v1_q) begin
        done_d = 1'b1; acc_d = 1'b0; busy_d = 1'b0;
      end else begin
        v1_d = iss_q;
        a1_d = ia_q;
        if (iss_q) begin
          ia_d  = ia_inc;
          iss_d = ia_inc < lim_q;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; iss_q <= 1'b0; v1_q <= 1'b0;
      ia_q <= '0; a1_q <= '0; lim_q <= '0; prev_q <= '0;
      done_q <= 1'b0; acc_q <= 1'b0; irq_q <= 1'b0; idx_q <= '0;
    end else begin
      busy_q <= busy_d; iss_q <= iss_d; v1_q <= v1_d;
      ia_q <= ia_d; a1_q <= a1_d; lim_q <= lim_d; prev_q <= prev_d;
      done_q <= done_d; acc_q <= acc_d; irq_q <= irq_d; idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kid_q <= '0; kct_q <= '0;
    end else if (key_ld) begin
      kid_q <= ext ? id : {{(EID_W-SID_W){1'b0}}, id[SID_W-1:0]};
      kct_q <= ctrl;
    end
  end

  assign ram_re    = busy_q && iss_q;
  assign ram_raddr = ia_q[AW-1:0];
  assign cmp_prev  = prev_q;
  assign key_id    = kid_q;
  assign key_ctrl  = kct_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign accept    = acc_q;
  assign hit_index = idx_q;
  assign rx_irq    = irq_q;

  // R9: the key of a search in progress is not replaced by a new request
  a_r9_key_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (!busy_q || ($stable(kid_q) && $stable(kct_q))));

  // R6: only addresses inside the frame's own range are compared
  a_r6_scan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && v1_q) |-> (a1_q < lim_q));

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_filt_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              lk_req,
  input  logic              lk_ext,
  input  logic [28:0]       lk_id,
  input  logic [2:0]        lk_ctrl,
  output logic              busy,
  output logic              done,
  output logic              accept,
  output logic [ADDR_W:0]   hit_index,
  output logic              rx_irq
);
  logic [1:0]                rs_q;
  logic                      rst_ni;
  logic                      wr_ok, ram_we, bnd_we;
  logic [NBND-1:0][ADDR_W:0] bnd;
  logic                      ram_re;
  logic [ADDR_W-1:0]         ram_raddr;
  logic [WORD_W-1:0]         ram_rdata, cmp_prev;
  sec_kind_e                 cmp_kind;
  logic                      cmp_pair_upper, cmp_hit, cmp_low_half;
  logic [EID_W-1:0]          key_id;
  logic [CTRL_W-1:0]         key_ctrl;
  logic                      unused_waddr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  assign wr_ok  = wr_en && !busy;
  assign ram_we = wr_ok && !wr_addr[ADDR_W];
  assign bnd_we = wr_ok && wr_addr[ADDR_W];
  assign unused_waddr = ^wr_addr[ADDR_W-1:3];

  filt_bounds #(.AW(ADDR_W)) u_bounds (
    .clk(clk), .rst_n(rst_ni), .wr_en(bnd_we), .wr_idx(wr_addr[2:0]),
    .wr_val(wr_data[ADDR_W:0]), .bnd(bnd)
  );

  filt_table_ram #(.AW(ADDR_W), .DW(WORD_W)) u_ram (
    .clk(clk), .rst_n(rst_ni), .scan_busy(busy), .we(ram_we),
    .waddr(wr_addr[ADDR_W-1:0]), .wdata(wr_data),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  filt_scan_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_ni), .req(lk_req), .ext(lk_ext), .id(lk_id),
    .ctrl(lk_ctrl), .bnd(bnd), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .ram_rdata(ram_rdata), .cmp_kind(cmp_kind), .cmp_pair_upper(cmp_pair_upper),
    .cmp_prev(cmp_prev), .key_id(key_id), .key_ctrl(key_ctrl),
    .cmp_hit(cmp_hit), .cmp_low_half(cmp_low_half), .busy(busy), .done(done),
    .accept(accept), .hit_index(hit_index), .rx_irq(rx_irq)
  );

  filt_match u_match (
    .kind(cmp_kind), .word(ram_rdata), .prev_word(cmp_prev),
    .pair_upper(cmp_pair_upper), .key_id(key_id), .key_ctrl(key_ctrl),
    .hit(cmp_hit), .hit_low_half(cmp_low_half)
  );

  // R7: done lasts exactly one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

  // R7: the interrupt only accompanies an accepted result
  a_r7_irq_on_accept: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_irq |-> (done && accept));

  // R7: the result is held after the done strobe
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(done) |-> ($stable(accept) && $stable(hit_index)));

endmodule

// File: tb/tb_can_id_filter.sv
module tb_can_id_filter;
  localparam int AW = 6;

  logic          clk, rst_n, wr_en, lk_req, lk_ext;
  logic [AW:0]   wr_addr;
  logic [31:0]   wr_data;
  logic [28:0]   lk_id;
  logic [2:0]    lk_ctrl;
  logic          busy, done, accept, rx_irq;
  logic [AW:0]   hit_index;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic r_acc, r_irq;
  logic [AW:0] r_idx;

  can_id_filter #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lk_req(lk_req), .lk_ext(lk_ext), .lk_id(lk_id), .lk_ctrl(lk_ctrl),
    .busy(busy), .done(done), .accept(accept), .hit_index(hit_index), .rx_irq(rx_irq)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic logic [15:0] se(input logic [2:0] c, input logic [10:0] i);
    return {c, 2'b00, i};
  endfunction
  function automatic logic [31:0] ee(input logic [2:0] c, input logic [28:0] i);
    return {c, i};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ram(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = {1'b0, AW'(a)}; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr_bnd(input int r, input int v);
    @(negedge clk);
    wr_en = 1; wr_addr = {1'b1, AW'(r)}; wr_data = 32'(v);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    check(done, "R7 search ends with done", 0, 1);
    r_acc = accept; r_irq = rx_irq; r_idx = hit_index;
  endtask

  task automatic lookup(input bit x, input logic [28:0] id, input logic [2:0] c);
    @(negedge clk);
    lk_req = 1; lk_ext = x; lk_id = id; lk_ctrl = c;
    @(negedge clk);
    lk_req = 0;
    wait_done();
  endtask

  task automatic expect_hit(input string tag, input bit x, input logic [28:0] id,
                            input logic [2:0] c, input int idx);
    lookup(x, id, c);
    check(r_acc === 1'b1 && r_irq === 1'b1, tag, {r_acc, r_irq}, 2'b11);
    check(r_idx === (AW+1)'(idx), tag, r_idx, idx);
  endtask

  task automatic expect_miss(input string tag, input bit x, input logic [28:0] id,
                             input logic [2:0] c);
    lookup(x, id, c);
    check(r_acc === 1'b0 && r_irq === 1'b0, tag, {r_acc, r_irq}, 2'b00);
  endtask

  task automatic t_reset();
    check(!busy && !done && !accept && !rx_irq, "R1 reset outputs",
          {busy, done, accept, rx_irq}, 0);
    expect_miss("R1 empty tables after reset", 1'b0, 29'h123, 3'd1);
  endtask

  task automatic t_load();
    wr_bnd(0, 0); wr_bnd(1, 3); wr_bnd(2, 5); wr_bnd(3, 7); wr_bnd(4, 11);  // R11
    wr_ram(0, {se(1, 11'h123), se(2, 11'h123)});
    wr_ram(1, {se(0, 11'h7FF), se(3, 11'h001)});
    wr_ram(2, {se(5, 11'h200), se(1, 11'h123)});
    wr_ram(3, {se(1, 11'h300), se(1, 11'h30F)});
    wr_ram(4, {se(4, 11'h400), se(4, 11'h4FF)});
    wr_ram(5, ee(3, 29'h1ABCDEF0));
    wr_ram(6, ee(0, 29'h123));
    wr_ram(7, ee(2, 29'h01000000));
    wr_ram(8, ee(2, 29'h01FFFFFF));
    wr_ram(9, ee(5, 29'h10));
    wr_ram(10, ee(5, 29'h20));
  endtask

  task automatic t_std_single();
    expect_hit("R2 upper half entry", 1'b0, 29'h123, 3'd1, 0);   // also R6 first of duplicates
    expect_hit("R2 lower half entry", 1'b0, 29'h123, 3'd2, 1);
    expect_hit("R2 lower half word1", 1'b0, 29'h001, 3'd3, 3);
    expect_hit("R2 max identifier",   1'b0, 29'h7FF, 3'd0, 2);
    expect_miss("R12 ctrl mismatch std", 1'b0, 29'h123, 3'd4);
  endtask

  task automatic t_std_range();
    expect_hit("R3 range low edge",  1'b0, 29'h300, 3'd1, 6);
    expect_hit("R3 range high edge", 1'b0, 29'h30F, 3'd1, 6);
    expect_miss("R3 above range",    1'b0, 29'h310, 3'd1);
    expect_miss("R12 range ctrl mismatch", 1'b0, 29'h305, 3'd2);
    expect_hit("R3 second range",    1'b0, 29'h4AB, 3'd4, 8);
  endtask

  task automatic t_ext();
    expect_hit("R4 ext single",  1'b1, 29'h1ABCDEF0, 3'd3, 5);
    expect_hit("R4 ext small id", 1'b1, 29'h123, 3'd0, 6);
    expect_miss("R6 std frame skips ext entry", 1'b0, 29'h123, 3'd0);
    expect_miss("R6 ext frame skips std entry", 1'b1, 29'h123, 3'd1);
    expect_hit("R5 ext range mid",   1'b1, 29'h01800000, 3'd2, 7);
    expect_hit("R5 ext range low",   1'b1, 29'h01000000, 3'd2, 7);
    expect_miss("R5 ext above range", 1'b1, 29'h02000000, 3'd2);
    expect_hit("R5 second pair",     1'b1, 29'h15, 3'd5, 9);
    expect_miss("R5 past second pair", 1'b1, 29'h21, 3'd5);
  endtask

  task automatic t_result_hold();
    expect_hit("R7 setup hit", 1'b0, 29'h001, 3'd3, 3);
    @(negedge clk);
    check(!done && !rx_irq, "R7 done and irq one cycle", {done, rx_irq}, 0);
    check(accept && hit_index == 3, "R7 result held", {accept, hit_index}, {1'b1, 7'd3});
  endtask

  task automatic t_req_while_busy();
    int extra = 0;
    @(negedge clk);
    lk_req = 1; lk_ext = 0; lk_id = 29'h001; lk_ctrl = 3'd3;
    @(negedge clk);
    lk_ext = 0; lk_id = 29'h123; lk_ctrl = 3'd1;   // still requesting while busy
    check(busy, "R9 busy during search", busy, 1);
    @(negedge clk);
    lk_req = 0;
    wait_done();
    check(r_acc && r_idx == 3, "R9 first request result", r_idx, 3);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R9 no second done", extra, 0);
  endtask

  task automatic t_write_while_busy();
    @(negedge clk);
    lk_req = 1; lk_ext = 0; lk_id = 29'h123; lk_ctrl = 3'd4;
    @(negedge clk);
    lk_req = 0;
    wr_en = 1; wr_addr = {1'b0, AW'(0)}; wr_data = {se(6, 11'h0AA), se(6, 11'h0AA)};
    @(negedge clk);
    wr_en = 1; wr_addr = {1'b1, AW'(2)}; wr_data = 32'd3;
    @(negedge clk);
    wr_en = 0;
    wait_done();
    expect_hit("R10 table unchanged", 1'b0, 29'h123, 3'd1, 0);
    expect_hit("R10 bound unchanged", 1'b0, 29'h4AB, 3'd4, 8);
  endtask

  task automatic t_empty();
    wr_bnd(4, 7);
    expect_miss("R8 empty ext range section", 1'b1, 29'h15, 3'd5);
    expect_hit("R11 end pointer keeps ext single", 1'b1, 29'h123, 3'd0, 6);
    wr_bnd(0, 5); wr_bnd(1, 5);
    expect_miss("R8 empty standard sections", 1'b0, 29'h123, 3'd1);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    lk_req = 0; lk_ext = 0; lk_id = '0; lk_ctrl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load();
    t_std_single();
    t_std_range();
    t_ext();
    t_result_hold();
    t_req_while_busy();
    t_write_while_busy();
    t_empty();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule